// File: doc/BRIEF.md
# Escape-Extended Nibble Opcode Decoder

This block turns a stream of 4-bit opcode nibbles into operation numbers for the microcode sequencer of a small channel processor. The most frequent operations fit in one nibble. The top few nibble values are prefixes. A prefix is never an operation by itself: it tells the decoder that the next nibble picks an extended operation. With the default parameters, 13 nibble values are direct operations and 3 are prefixes, each opening a page of 16 extended operations. That gives 61 operations, numbered 0 to 60.

Nibbles arrive through a valid/ready handshake. One cycle after the decoder accepts the last nibble of an instruction, it raises a one-cycle strobe on its output and presents the operation number and a register-select field. The register-select field comes from the low two bits of the second nibble of an extended instruction. If that field names a register the processor does not have, the decoder raises an illegal-encoding strobe in place of the valid strobe. The abort input throws away a half-received prefix sequence, for example when the processor switches channel.

The decoder has two named states. `ST_IDLE` waits for a primary nibble. `ST_PEND` holds a captured prefix. The transitions are:
- `ST_IDLE` to `ST_PEND` when a prefix nibble is accepted.
- `ST_PEND` to `ST_IDLE` when a second nibble is accepted.
- `ST_PEND` to `ST_IDLE` on abort.
- Any state to `ST_IDLE` on reset.
- Every other cycle keeps the current state.

Top module: `nibble_opdec`

## Requirements
- R1: Synchronous reset returns the decoder to `ST_IDLE`. It clears both strobes and sets the operation and register outputs to zero. After reset, the next accepted nibble is decoded as a primary nibble.
- R2: `in_ready` is the inverse of `abort`. A nibble is accepted only in a cycle where `in_valid` and `in_ready` are both high.
- R3: In `ST_IDLE`, an accepted nibble below 13 raises `dec_valid` for exactly one cycle, starting the cycle after acceptance. In that cycle `dec_op` equals the nibble value and `dec_reg` is 0.
- R4: In `ST_IDLE`, an accepted nibble of 13, 14 or 15 is a prefix. It raises no strobe, and the decoder moves to `ST_PEND`.
- R5: In `ST_PEND`, the next accepted nibble s completes the instruction. One cycle later `dec_op` equals 13 + 16*(p-13) + s, where p is the prefix. The result always lies between 13 and 60.
- R6: For an extended instruction, `dec_reg` equals bits [1:0] of the second nibble.
- R7: For an extended instruction whose register field is not below NUM_REGS, the decoder raises `dec_illegal` in place of `dec_valid`. `dec_op` and `dec_reg` still show the offending encoding.
- R8: While `abort` is high, the decoder discards any captured prefix, raises no strobe and accepts no nibble. The nibble accepted after the abort is decoded as a primary nibble.
- R9: Cycles with no accepted nibble raise no strobe, keep the captured prefix, and leave `dec_op` and `dec_reg` unchanged.
- R10: In `ST_PEND`, the values 13 to 15 are treated as ordinary second nibbles, not as new prefixes.
- R11: `dec_valid` and `dec_illegal` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A nibble is offered |
| in_nibble | input | 4 | Offered opcode nibble |
| in_ready | output | 1 | Decoder can take a nibble this cycle |
| abort | input | 1 | Discard any half-received prefix sequence |
| dec_valid | output | 1 | One-cycle strobe: a legal instruction was decoded |
| dec_illegal | output | 1 | One-cycle strobe: an encoding with a bad register field was decoded |
| dec_op | output | 6 | Unified operation number, 0 to 60 |
| dec_reg | output | 2 | Register-select field |

## Verification
The bench builds two copies of the decoder from the same stimulus. One has NUM_REGS set to 3 and the other has NUM_REGS set to 2. With three registers, only register field 3 is illegal. With two registers, fields 2 and 3 are both illegal. Running both copies therefore checks that the legality boundary follows the parameter instead of a fixed value. Every prefix is paired with all sixteen second nibbles, which covers both ends of the operation range (13 and 60). The stimulus also places idle gaps, aborts and resets while a prefix is pending, and the bench compares all outputs of both copies against a behavioural model on every clock.

// File: rtl/nibdec_pkg.sv
package nibdec_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } dec_state_e;

endpackage

// File: rtl/nibdec_fsm.sv
module nibdec_fsm
    import nibdec_pkg::*;
#(
    parameter int NIB_W   = 4,
    parameter int NUM_ESC = 3,
    localparam int NUM_DIRECT = (1 << NIB_W) - NUM_ESC,
    localparam int ESC_W = (NUM_ESC > 1) ? $clog2(NUM_ESC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             accept,
    input  logic [NIB_W-1:0] nibble,
    output dec_state_e       state,
    output logic [ESC_W-1:0] esc_idx,
    output logic             is_prefix
);

    dec_state_e       state_nx;
    logic [ESC_W-1:0] esc_nx;

    // A nibble at or above the first prefix value opens an extended page.
    assign is_prefix = (nibble >= NIB_W'(NUM_DIRECT));

    always_comb begin
        state_nx = state;
        esc_nx   = esc_idx;
        if (abort) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept && is_prefix) begin
                        state_nx = ST_PEND;
                        esc_nx   = ESC_W'(nibble - NIB_W'(NUM_DIRECT));
                    end
                end
                ST_PEND: begin
                    if (accept) state_nx = ST_IDLE;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            esc_idx <= '0;
        end else begin
            state   <= state_nx;
            esc_idx <= esc_nx;
        end
    end

    // R8: an abort leaves no prefix pending in the next cycle
    assert_abort_clears_R8: assert property (@(posedge clk) disable iff (rst)
        abort |=> (state == ST_IDLE));

    // R10: a second nibble never re-opens a page, even when it is a prefix value
    assert_no_reprefix_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PEND && accept && !abort) |=> (state == ST_IDLE));

endmodule

// File: rtl/nibdec_compose.sv
module nibdec_compose
    import nibdec_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int NUM_ESC     = 3,
    parameter int NUM_REGS    = 3,
    parameter int REG_FIELD_W = 2,
    localparam int NUM_DIRECT = (1 << NIB_W) - NUM_ESC,
    localparam int NUM_OPS    = NUM_DIRECT + NUM_ESC * (1 << NIB_W),
    localparam int OP_W       = $clog2(NUM_OPS),
    localparam int ESC_W      = (NUM_ESC > 1) ? $clog2(NUM_ESC) : 1
) (
    input  dec_state_e             state,
    input  logic [ESC_W-1:0]       esc_idx,
    input  logic [NIB_W-1:0]       nibble,
    output logic [OP_W-1:0]        op_num,
    output logic [REG_FIELD_W-1:0] reg_field,
    output logic                   reg_legal
);

    logic [OP_W-1:0] page_base;

    // Page base = first extended number + prefix index times page size.
    assign page_base = OP_W'(NUM_DIRECT) + OP_W'({esc_idx, {NIB_W{1'b0}}});

    always_comb begin
        unique case (state)
            ST_PEND: begin
                op_num    = page_base + OP_W'(nibble);
                reg_field = nibble[REG_FIELD_W-1:0];
            end
            default: begin
                op_num    = OP_W'(nibble);
                reg_field = '0;
            end
        endcase
    end

    assign reg_legal = (32'(reg_field) < 32'(NUM_REGS));

endmodule

// File: rtl/nibble_opdec.sv
module nibble_opdec
    import nibdec_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int NUM_ESC     = 3,
    parameter int NUM_REGS    = 3,
    parameter int REG_FIELD_W = 2,
    localparam int NUM_DIRECT = (1 << NIB_W) - NUM_ESC,
    localparam int NUM_OPS    = NUM_DIRECT + NUM_ESC * (1 << NIB_W),
    localparam int OP_W       = $clog2(NUM_OPS),
    localparam int ESC_W      = (NUM_ESC > 1) ? $clog2(NUM_ESC) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [NIB_W-1:0]       in_nibble,
    output logic                   in_ready,
    input  logic                   abort,
    output logic                   dec_valid,
    output logic                   dec_illegal,
    output logic [OP_W-1:0]        dec_op,
    output logic [REG_FIELD_W-1:0] dec_reg
);

    dec_state_e             state;
    logic [ESC_W-1:0]       esc_idx;
    logic                   is_prefix;
    logic                   accept;
    logic [OP_W-1:0]        op_num;
    logic [REG_FIELD_W-1:0] reg_field;
    logic                   reg_legal;

    assign in_ready = !abort;
    assign accept   = in_valid && in_ready;

    nibdec_fsm #(.NIB_W(NIB_W), .NUM_ESC(NUM_ESC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .abort     (abort),
        .accept    (accept),
        .nibble    (in_nibble),
        .state     (state),
        .esc_idx   (esc_idx),
        .is_prefix (is_prefix)
    );

    nibdec_compose #(
        .NIB_W(NIB_W), .NUM_ESC(NUM_ESC),
        .NUM_REGS(NUM_REGS), .REG_FIELD_W(REG_FIELD_W)
    ) u_compose (
        .state     (state),
        .esc_idx   (esc_idx),
        .nibble    (in_nibble),
        .op_num    (op_num),
        .reg_field (reg_field),
        .reg_legal (reg_legal)
    );

    // Output process: strobes for one cycle, number and field hold otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid   <= 1'b0;
            dec_illegal <= 1'b0;
            dec_op      <= '0;
            dec_reg     <= '0;
        end else begin
            dec_valid   <= 1'b0;
            dec_illegal <= 1'b0;
            if (accept) begin
                unique case (state)
                    ST_IDLE: begin
                        if (!is_prefix) begin
                            dec_valid <= 1'b1;
                            dec_op    <= op_num;
                            dec_reg   <= reg_field;
                        end
                    end
                    ST_PEND: begin
                        dec_valid   <= reg_legal;
                        dec_illegal <= !reg_legal;
                        dec_op      <= op_num;
                        dec_reg     <= reg_field;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: reset leaves both strobes low
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!dec_valid && !dec_illegal));

    // R3: a direct nibble in idle is reported unchanged one cycle later
    assert_direct_op_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && in_valid && in_ready && !is_prefix)
        |=> (dec_valid && dec_op == OP_W'($past(in_nibble)) && dec_reg == '0));

    // R4: a prefix nibble raises no strobe
    assert_prefix_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && in_valid && in_ready && is_prefix)
        |=> (!dec_valid && !dec_illegal));

    // R5: a reported operation lies within the encodable range
    assert_op_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid || dec_illegal) |-> (32'(dec_op) < NUM_OPS));

    // R7: the illegal strobe only ever reports an absent register
    assert_illegal_reg_R7: assert property (@(posedge clk) disable iff (rst)
        dec_illegal |-> (32'(dec_reg) >= NUM_REGS));

    // R9: without an accepted nibble, nothing is reported next cycle
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> (!dec_valid && !dec_illegal && $stable(dec_op)));

    // R11: the two strobes are exclusive
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(dec_valid && dec_illegal));

endmodule

// File: tb/nibble_opdec_test.sv
module nibble_opdec_test;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [3:0] in_nibble;
    logic       abort;

    logic       rdy_a, val_a, ill_a, rdy_b, val_b, ill_b;
    logic [5:0] op_a, op_b;
    logic [1:0] reg_a, reg_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nibble_opdec #(.NUM_REGS(3)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_nibble(in_nibble),
        .in_ready(rdy_a), .abort(abort), .dec_valid(val_a),
        .dec_illegal(ill_a), .dec_op(op_a), .dec_reg(reg_a)
    );

    nibble_opdec #(.NUM_REGS(2)) uut2 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_nibble(in_nibble),
        .in_ready(rdy_b), .abort(abort), .dec_valid(val_b),
        .dec_illegal(ill_b), .dec_op(op_b), .dec_reg(reg_b)
    );

    // behavioural model, index 0 = three registers, index 1 = two registers
    int    m_nregs [2] = '{3, 2};
    bit    m_pend  [2];
    int    m_pre   [2];
    bit    m_val   [2];
    bit    m_ill   [2];
    int    m_op    [2];
    int    m_reg   [2];
    string t_strobe [2];
    string t_op     [2];
    string t_reg    [2];

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(t_strobe[0], int'(val_a), int'(m_val[0]), "valid(3 regs)");
        chk(t_strobe[0], int'(ill_a), int'(m_ill[0]), "illegal(3 regs)");
        chk(t_op[0], int'(op_a), m_op[0], "op(3 regs)");
        chk(t_reg[0], int'(reg_a), m_reg[0], "reg(3 regs)");
        chk(t_strobe[1], int'(val_b), int'(m_val[1]), "valid(2 regs)");
        chk(t_strobe[1], int'(ill_b), int'(m_ill[1]), "illegal(2 regs)");
        chk(t_op[1], int'(op_b), m_op[1], "op(2 regs)");
        chk(t_reg[1], int'(reg_b), m_reg[1], "reg(2 regs)");
        chk("R11", int'(val_a && ill_a), 0, "both strobes(3 regs)");
        chk("R11", int'(val_b && ill_b), 0, "both strobes(2 regs)");
    endtask

    task automatic model_edge(input bit r, input bit v, input int n, input bit ab);
        for (int i = 0; i < 2; i++) begin
            m_val[i] = 1'b0;
            m_ill[i] = 1'b0;
            t_op[i]  = "R9";
            t_reg[i] = "R9";
            if (r) begin
                m_pend[i] = 1'b0;
                m_op[i] = 0; m_reg[i] = 0;
                t_strobe[i] = "R1"; t_op[i] = "R1"; t_reg[i] = "R1";
            end else if (ab) begin
                m_pend[i] = 1'b0;
                t_strobe[i] = "R8"; t_op[i] = "R8"; t_reg[i] = "R8";
            end else if (!v) begin
                t_strobe[i] = "R9";
            end else if (!m_pend[i]) begin
                if (n < 13) begin
                    m_val[i] = 1'b1;
                    m_op[i] = n; m_reg[i] = 0;
                    t_strobe[i] = "R3"; t_op[i] = "R3"; t_reg[i] = "R3";
                end else begin
                    m_pend[i] = 1'b1;
                    m_pre[i] = n;
                    t_strobe[i] = "R4"; t_op[i] = "R4"; t_reg[i] = "R4";
                end
            end else begin
                m_pend[i] = 1'b0;
                m_op[i]  = 13 + 16 * (m_pre[i] - 13) + n;
                m_reg[i] = n % 4;
                t_op[i]  = (n >= 13) ? "R10" : "R5";
                t_reg[i] = "R6";
                if (m_reg[i] >= m_nregs[i]) begin
                    m_ill[i] = 1'b1;
                    t_strobe[i] = "R7";
                end else begin
                    m_val[i] = 1'b1;
                    t_strobe[i] = "R5";
                end
            end
        end
    endtask

    bit first_step = 1'b1;

    task automatic step(input bit r, input bit v, input int n, input bit ab);
        @(negedge clk);
        if (!first_step) compare_all();
        first_step = 1'b0;
        rst = r; in_valid = v; in_nibble = 4'(n); abort = ab;
        #1;
        chk("R2", int'(rdy_a), int'(!ab), "in_ready(3 regs)");
        chk("R2", int'(rdy_b), int'(!ab), "in_ready(2 regs)");
        model_edge(r, v, n, ab);
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h1234_5678;
        rst = 1'b1; in_valid = 1'b0; in_nibble = 4'h0; abort = 1'b0;
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        // R3: all direct operations, back to back
        for (int n = 0; n < 13; n++) step(0, 1, n, 0);
        // R5 R6 R7 R10: every prefix with every second nibble
        for (int p = 13; p < 16; p++)
            for (int s = 0; s < 16; s++) begin
                step(0, 1, p, 0);
                step(0, 1, s, 0);
            end
        // R9: idle gaps while a prefix is pending
        step(0, 1, 14, 0);
        step(0, 0, 0, 0);
        step(0, 0, 9, 0);
        step(0, 1, 4, 0);
        step(0, 0, 0, 0);
        // R8: abort discards a pending prefix, nibble offered during abort ignored
        step(0, 1, 15, 0);
        step(0, 1, 2, 1);
        step(0, 1, 5, 0);
        step(0, 1, 13, 0);
        step(0, 0, 0, 1);
        step(0, 1, 15, 0);
        step(0, 1, 15, 0);
        // R1: reset while pending
        step(0, 1, 13, 0);
        step(1, 1, 7, 0);
        step(0, 1, 7, 0);
        // mixed stream
        for (int k = 0; k < 400; k++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            step(0, seed[20:18] != 3'd0, int'(seed[27:24]), seed[31:29] == 3'd0);
        end
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule